// File: doc/BRIEF.md
# Control-Endpoint Packet Buffer

This block holds one 64-byte packet for the bidirectional control endpoint of a USB device. It connects a byte-wide CPU register port to the packet port of the serial interface engine (SIE). To send data to the host, the CPU pushes bytes through a single data register, which steps an internal pointer. It then arms the endpoint by writing the packet length into a count register. When the host's IN token arrives, the SIE is told to send that many bytes, and it streams them out of the buffer. The endpoint stays armed until the SIE reports that the host acknowledged the packet.

For the host-to-device direction, the SIE pushes received bytes into the same storage. It then reports the packet as good or bad with a single strobe. Only a good packet that fits in the buffer loads the received length into the count register, raises the data-available interrupt flag and yields an ACK. While that flag is still set, further OUT packets are refused with NAK so unread data survives. A second, IN-only endpoint owns just a 7-bit count register with the same arm-on-write rule. The packet storage has no reset and keeps its contents across any reset.

Top module: `ctl_ep_buffer`

## Requirements
- R1: A CPU write to the data register (address 10h) stores the byte at the CPU pointer. A CPU read strobe at that address returns the byte at the pointer. Either access advances the pointer by one, and the pointer wraps from 63 to 0.
- R2: A write to the control count register (address 11h) stores min(wdata[6:0], 64) in bits 6:0, arms the control endpoint and rewinds the CPU pointer to 0. Bit 7 always reads 0.
- R3: An IN token (sie_ep_sel=0) gives a handshake one cycle later: NAK (code 1) when the endpoint is unarmed, DATA (code 3) when armed. sie_in_len then shows the armed count.
- R4: After an armed IN token, each sie_in_rd strobe steps through the buffer from index 0, and sie_in_data shows the current byte.
- R5: sie_in_ack for an endpoint clears that endpoint's armed state, so its next IN token is NAKed.
- R6: A good OUT packet of up to 64 bytes is stored from index 0. The count register takes its length, the data-available flag (flag register bit 0, also out_dav_irq) is set, and the handshake is ACK (code 2).
- R7: A bad OUT packet gives handshake code 0 (no reply). The count register and the data-available flag stay unchanged.
- R8: While the data-available flag is set, an OUT token gets NAK. The bytes and the completion of that packet change neither the buffer, the count nor the flag, and no handshake follows the completion.
- R9: Writing the flag register (address 12h) with bit 0 set clears data-available and rewinds the CPU pointer. Writing bit 0 as 0 changes neither. Flag bit 1 reads the control armed state and bit 2 the companion armed state.
- R10: The companion count register (address 0Eh) stores min(wdata[6:0], 64) and arms only the companion endpoint. IN tokens and acks with sie_ep_sel=1 follow R3 and R5 using it, and leave the control endpoint's state alone.
- R11: After reset, both count registers, both armed states, the flag and the CPU pointer are 0. The buffer contents are unchanged.
- R12: A good OUT packet longer than 64 bytes is treated as bad: code 0, with count and flag unchanged.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous reset, active low |
| cpu_addr | input | 5 | CPU register address |
| cpu_wr | input | 1 | CPU write strobe |
| cpu_rd | input | 1 | CPU read strobe (advances the data pointer) |
| cpu_wdata | input | 8 | CPU write data |
| cpu_rdata | output | 8 | CPU read data for cpu_addr |
| sie_ep_sel | input | 1 | Endpoint for IN token/ack: 0 control, 1 companion |
| sie_in_tok | input | 1 | IN token received |
| sie_in_rd | input | 1 | SIE takes the current IN byte |
| sie_in_data | output | 8 | Current IN byte |
| sie_in_len | output | 7 | Byte count to send after DATA |
| sie_in_ack | input | 1 | Host acknowledged the sent packet |
| sie_out_tok | input | 1 | OUT token received for the control endpoint |
| sie_out_wr | input | 1 | Received OUT byte valid |
| sie_out_data | input | 8 | Received OUT byte |
| sie_out_done | input | 1 | End of OUT packet |
| sie_out_good | input | 1 | Packet passed checking (with sie_out_done) |
| sie_hs_vld | output | 1 | Handshake decision valid |
| sie_hs_kind | output | 2 | 0 none, 1 NAK, 2 ACK, 3 DATA |
| out_dav_irq | output | 1 | OUT data-available interrupt flag |

## Verification
The IN path is exercised with tokens on an unarmed endpoint, an armed endpoint, and an endpoint whose packet was just acknowledged. This separates arming from acknowledge and keeps the two endpoints' states apart. OUT packets come in four kinds: short good, good while unread data is pending, bad, and one byte too long. These show whether the count and flag follow only clean packets and whether pending data is protected. A full 64-byte fill followed by one extra write exposes pointer wrap, and a reset in the middle of the test shows that registers clear while the stored bytes survive.

// File: rtl/ctl_ep_pkg.sv
package ctl_ep_pkg;

    typedef enum logic [1:0] {
        HS_QUIET = 2'd0,
        HS_NAK   = 2'd1,
        HS_ACK   = 2'd2,
        HS_DATA  = 2'd3
    } hs_kind_e;

endpackage

// File: rtl/ctl_ep_ram.sv
module ctl_ep_ram #(
    parameter int DEPTH = 64,
    parameter int DW    = 8,
    parameter int PW    = $clog2(DEPTH)
) (
    input  logic          clk,
    input  logic          we_a,
    input  logic [PW-1:0] waddr_a,
    input  logic [DW-1:0] wdata_a,
    input  logic          we_b,
    input  logic [PW-1:0] waddr_b,
    input  logic [DW-1:0] wdata_b,
    input  logic [PW-1:0] raddr_a,
    output logic [DW-1:0] rdata_a,
    input  logic [PW-1:0] raddr_b,
    output logic [DW-1:0] rdata_b
);

    // no reset: contents survive every reset
    logic [DW-1:0] mem [DEPTH];

    always_ff @(posedge clk) begin
        if (we_a) mem[waddr_a] <= wdata_a;
        if (we_b) mem[waddr_b] <= wdata_b;   // SIE port wins on a clash
    end

    assign rdata_a = mem[raddr_a];
    assign rdata_b = mem[raddr_b];

endmodule

// File: rtl/ctl_ep_rdmux.sv
module ctl_ep_rdmux #(
    parameter int         DW       = 8,
    parameter int         CW       = 7,
    parameter int         RA_W     = 5,
    parameter logic [4:0] ADR_AUX  = 5'h0E,
    parameter logic [4:0] ADR_DATA = 5'h10,
    parameter logic [4:0] ADR_CNT  = 5'h11,
    parameter logic [4:0] ADR_FLAG = 5'h12
) (
    input  logic [RA_W-1:0] addr,
    input  logic [DW-1:0]   buf_byte,
    input  logic [CW-1:0]   cnt,
    input  logic [CW-1:0]   aux_cnt,
    input  logic            armed,
    input  logic            aux_armed,
    input  logic            dav,
    output logic [DW-1:0]   rdata
);

    always_comb begin
        rdata = '0;
        if (addr == RA_W'(ADR_DATA))      rdata = buf_byte;
        else if (addr == RA_W'(ADR_CNT))  rdata = DW'(cnt);
        else if (addr == RA_W'(ADR_AUX))  rdata = DW'(aux_cnt);
        else if (addr == RA_W'(ADR_FLAG)) rdata = DW'({aux_armed, armed, dav});
    end

endmodule

// File: rtl/ctl_ep_core.sv
module ctl_ep_core
    import ctl_ep_pkg::*;
#(
    parameter int         DEPTH    = 64,
    parameter int         RA_W     = 5,
    parameter logic [4:0] ADR_AUX  = 5'h0E,
    parameter logic [4:0] ADR_DATA = 5'h10,
    parameter logic [4:0] ADR_CNT  = 5'h11,
    parameter logic [4:0] ADR_FLAG = 5'h12,
    parameter int         PW       = $clog2(DEPTH),
    parameter int         CW       = PW + 1
) (
    input  logic            clk,
    input  logic            rst_n,
    input  logic [RA_W-1:0] cpu_addr,
    input  logic            cpu_wr,
    input  logic            cpu_rd,
    input  logic [CW-1:0]   cpu_wlen,
    input  logic            sie_ep_sel,
    input  logic            sie_in_tok,
    input  logic            sie_in_rd,
    input  logic            sie_in_ack,
    input  logic            sie_out_tok,
    input  logic            sie_out_wr,
    input  logic            sie_out_done,
    input  logic            sie_out_good,
    output logic            ram_cpu_we,
    output logic            ram_sie_we,
    output logic [PW-1:0]   cpu_ptr,
    output logic [PW-1:0]   sie_addr,
    output logic            hs_vld,
    output hs_kind_e        hs_kind,
    output logic [CW-1:0]   in_len,
    output logic [CW-1:0]   cnt,
    output logic [CW-1:0]   aux_cnt,
    output logic            armed,
    output logic            aux_armed,
    output logic            dav
);

    localparam logic [CW-1:0] FULL = CW'(DEPTH);

    typedef struct packed {
        logic [CW-1:0] cnt;
        logic [CW-1:0] aux_cnt;
        logic          armed;
        logic          aux_armed;
        logic          dav;
        logic [PW-1:0] cpu_ptr;
        logic [CW-1:0] sie_ptr;
        logic          rx_on;
        logic          rx_ovf;
        logic          hs_vld;
        hs_kind_e      hs_kind;
        logic [CW-1:0] tx_len;
    } st_t;

    st_t s_d, s_q;

    function automatic logic [CW-1:0] clamp_len(input logic [CW-1:0] v);
        return (v > FULL) ? FULL : v;
    endfunction

    always_comb begin
        s_d         = s_q;
        s_d.hs_vld  = 1'b0;
        s_d.hs_kind = HS_QUIET;
        ram_cpu_we  = 1'b0;
        ram_sie_we  = 1'b0;

        // host acknowledged an IN packet; a CPU re-arm below takes priority
        if (sie_in_ack) begin
            if (sie_ep_sel) s_d.aux_armed = 1'b0;
            else            s_d.armed     = 1'b0;
        end

        // CPU register port
        if (cpu_wr) begin
            if (cpu_addr == RA_W'(ADR_DATA)) begin
                ram_cpu_we  = 1'b1;
                s_d.cpu_ptr = s_q.cpu_ptr + 1'b1;
            end else if (cpu_addr == RA_W'(ADR_CNT)) begin
                s_d.cnt     = clamp_len(cpu_wlen);
                s_d.armed   = 1'b1;
                s_d.cpu_ptr = '0;
            end else if (cpu_addr == RA_W'(ADR_AUX)) begin
                s_d.aux_cnt   = clamp_len(cpu_wlen);
                s_d.aux_armed = 1'b1;
            end else if (cpu_addr == RA_W'(ADR_FLAG) && cpu_wlen[0]) begin
                s_d.dav     = 1'b0;
                s_d.cpu_ptr = '0;
            end
        end else if (cpu_rd && cpu_addr == RA_W'(ADR_DATA)) begin
            s_d.cpu_ptr = s_q.cpu_ptr + 1'b1;
        end

        // IN token and streaming
        if (sie_in_tok) begin
            s_d.hs_vld = 1'b1;
            if (sie_ep_sel) begin
                s_d.hs_kind = s_q.aux_armed ? HS_DATA : HS_NAK;
                s_d.tx_len  = s_q.aux_cnt;
            end else begin
                s_d.hs_kind = s_q.armed ? HS_DATA : HS_NAK;
                s_d.tx_len  = s_q.cnt;
                s_d.sie_ptr = '0;
            end
        end else if (sie_in_rd) begin
            s_d.sie_ptr = s_q.sie_ptr + 1'b1;
        end

        // OUT token: refuse while unread data is pending
        if (sie_out_tok) begin
            if (s_q.dav) begin
                s_d.hs_vld  = 1'b1;
                s_d.hs_kind = HS_NAK;
                s_d.rx_on   = 1'b0;
            end else begin
                s_d.rx_on   = 1'b1;
                s_d.rx_ovf  = 1'b0;
                s_d.sie_ptr = '0;
            end
        end

        if (sie_out_wr && s_q.rx_on) begin
            if (s_q.sie_ptr == FULL) begin
                s_d.rx_ovf = 1'b1;
            end else begin
                ram_sie_we  = 1'b1;
                s_d.sie_ptr = s_q.sie_ptr + 1'b1;
            end
        end

        if (sie_out_done && s_q.rx_on) begin
            s_d.rx_on  = 1'b0;
            s_d.hs_vld = 1'b1;
            if (sie_out_good && !s_q.rx_ovf) begin
                s_d.cnt     = s_q.sie_ptr;
                s_d.dav     = 1'b1;
                s_d.hs_kind = HS_ACK;
            end else begin
                s_d.hs_kind = HS_QUIET;
            end
        end
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) s_q <= '0;
        else        s_q <= s_d;
    end

    assign cpu_ptr   = s_q.cpu_ptr;
    assign sie_addr  = s_q.sie_ptr[PW-1:0];
    assign hs_vld    = s_q.hs_vld;
    assign hs_kind   = s_q.hs_kind;
    assign in_len    = s_q.tx_len;
    assign cnt       = s_q.cnt;
    assign aux_cnt   = s_q.aux_cnt;
    assign armed     = s_q.armed;
    assign aux_armed = s_q.aux_armed;
    assign dav       = s_q.dav;

endmodule

// File: rtl/ctl_ep_buffer.sv
module ctl_ep_buffer
    import ctl_ep_pkg::*;
#(
    parameter int         DEPTH    = 64,
    parameter int         DW       = 8,
    parameter int         RA_W     = 5,
    parameter logic [4:0] ADR_AUX  = 5'h0E,
    parameter logic [4:0] ADR_DATA = 5'h10,
    parameter logic [4:0] ADR_CNT  = 5'h11,
    parameter logic [4:0] ADR_FLAG = 5'h12,
    parameter int         PW       = $clog2(DEPTH),
    parameter int         CW       = PW + 1
) (
    input  logic            clk,
    input  logic            rst_n,
    input  logic [RA_W-1:0] cpu_addr,
    input  logic            cpu_wr,
    input  logic            cpu_rd,
    input  logic [DW-1:0]   cpu_wdata,
    output logic [DW-1:0]   cpu_rdata,
    input  logic            sie_ep_sel,
    input  logic            sie_in_tok,
    input  logic            sie_in_rd,
    output logic [DW-1:0]   sie_in_data,
    output logic [CW-1:0]   sie_in_len,
    input  logic            sie_in_ack,
    input  logic            sie_out_tok,
    input  logic            sie_out_wr,
    input  logic [DW-1:0]   sie_out_data,
    input  logic            sie_out_done,
    input  logic            sie_out_good,
    output logic            sie_hs_vld,
    output logic [1:0]      sie_hs_kind,
    output logic            out_dav_irq
);

    logic          ram_cpu_we, ram_sie_we;
    logic [PW-1:0] cpu_ptr, sie_addr;
    logic [DW-1:0] cpu_byte;
    logic [CW-1:0] st_cnt, st_aux_cnt;
    logic          st_armed, st_aux_armed;
    hs_kind_e      hs_kind;

    ctl_ep_core #(
        .DEPTH(DEPTH), .RA_W(RA_W),
        .ADR_AUX(ADR_AUX), .ADR_DATA(ADR_DATA), .ADR_CNT(ADR_CNT), .ADR_FLAG(ADR_FLAG)
    ) u_core (
        .clk          (clk),
        .rst_n        (rst_n),
        .cpu_addr     (cpu_addr),
        .cpu_wr       (cpu_wr),
        .cpu_rd       (cpu_rd),
        .cpu_wlen     (cpu_wdata[CW-1:0]),
        .sie_ep_sel   (sie_ep_sel),
        .sie_in_tok   (sie_in_tok),
        .sie_in_rd    (sie_in_rd),
        .sie_in_ack   (sie_in_ack),
        .sie_out_tok  (sie_out_tok),
        .sie_out_wr   (sie_out_wr),
        .sie_out_done (sie_out_done),
        .sie_out_good (sie_out_good),
        .ram_cpu_we   (ram_cpu_we),
        .ram_sie_we   (ram_sie_we),
        .cpu_ptr      (cpu_ptr),
        .sie_addr     (sie_addr),
        .hs_vld       (sie_hs_vld),
        .hs_kind      (hs_kind),
        .in_len       (sie_in_len),
        .cnt          (st_cnt),
        .aux_cnt      (st_aux_cnt),
        .armed        (st_armed),
        .aux_armed    (st_aux_armed),
        .dav          (out_dav_irq)
    );

    ctl_ep_ram #(.DEPTH(DEPTH), .DW(DW)) u_ram (
        .clk     (clk),
        .we_a    (ram_cpu_we),
        .waddr_a (cpu_ptr),
        .wdata_a (cpu_wdata),
        .we_b    (ram_sie_we),
        .waddr_b (sie_addr),
        .wdata_b (sie_out_data),
        .raddr_a (cpu_ptr),
        .rdata_a (cpu_byte),
        .raddr_b (sie_addr),
        .rdata_b (sie_in_data)
    );

    ctl_ep_rdmux #(
        .DW(DW), .CW(CW), .RA_W(RA_W),
        .ADR_AUX(ADR_AUX), .ADR_DATA(ADR_DATA), .ADR_CNT(ADR_CNT), .ADR_FLAG(ADR_FLAG)
    ) u_rdmux (
        .addr      (cpu_addr),
        .buf_byte  (cpu_byte),
        .cnt       (st_cnt),
        .aux_cnt   (st_aux_cnt),
        .armed     (st_armed),
        .aux_armed (st_aux_armed),
        .dav       (out_dav_irq),
        .rdata     (cpu_rdata)
    );

    assign sie_hs_kind = hs_kind;

endmodule

// File: rtl/ctl_ep_chk.sv
module ctl_ep_chk
    import ctl_ep_pkg::*;
#(
    parameter int         DEPTH   = 64,
    parameter int         DW      = 8,
    parameter int         RA_W    = 5,
    parameter logic [4:0] ADR_CNT = 5'h11,
    parameter int         CW      = $clog2(DEPTH) + 1
) (
    input logic            clk,
    input logic            rst_n,
    input logic [RA_W-1:0] cpu_addr,
    input logic            cpu_wr,
    input logic [DW-1:0]   cpu_rdata,
    input logic            sie_ep_sel,
    input logic            sie_in_tok,
    input logic            sie_in_ack,
    input logic [CW-1:0]   sie_in_len,
    input logic            sie_out_tok,
    input logic            sie_out_done,
    input logic            sie_out_good,
    input logic            sie_hs_vld,
    input logic [1:0]      sie_hs_kind,
    input logic            out_dav_irq,
    input logic [CW-1:0]   st_cnt,
    input logic            st_armed
);

    logic cnt_wr;
    assign cnt_wr = cpu_wr && (cpu_addr == RA_W'(ADR_CNT));

    AST_IN_UNARMED_NAK: assert property (@(posedge clk) disable iff (!rst_n)
        sie_in_tok && !sie_ep_sel && !st_armed |=> sie_hs_vld && sie_hs_kind == HS_NAK); // R3

    AST_IN_ARMED_DATA: assert property (@(posedge clk) disable iff (!rst_n)
        sie_in_tok && !sie_ep_sel && st_armed
        |=> sie_hs_vld && sie_hs_kind == HS_DATA && sie_in_len == $past(st_cnt)); // R3

    AST_ACK_DISARMS: assert property (@(posedge clk) disable iff (!rst_n)
        sie_in_ack && !sie_ep_sel && !cnt_wr |=> !st_armed); // R5

    AST_PENDING_OUT_NAK: assert property (@(posedge clk) disable iff (!rst_n)
        sie_out_tok && out_dav_irq |=> sie_hs_vld && sie_hs_kind == HS_NAK); // R8

    AST_BAD_KEEPS_COUNT: assert property (@(posedge clk) disable iff (!rst_n)
        sie_out_done && !sie_out_good && !cnt_wr
        |=> $stable(st_cnt) && !(sie_hs_vld && sie_hs_kind == HS_ACK)); // R7

    AST_ACK_WITH_FLAG: assert property (@(posedge clk) disable iff (!rst_n)
        sie_hs_vld && sie_hs_kind == HS_ACK |-> out_dav_irq); // R6

    AST_COUNT_LIMIT: assert property (@(posedge clk) disable iff (!rst_n)
        st_cnt <= CW'(DEPTH)); // R2

    AST_RESERVED_ZERO: assert property (@(posedge clk) disable iff (!rst_n)
        cpu_addr == RA_W'(ADR_CNT) |-> cpu_rdata[DW-1] == 1'b0); // R2

endmodule

bind ctl_ep_buffer ctl_ep_chk #(
    .DEPTH(DEPTH), .DW(DW), .RA_W(RA_W), .ADR_CNT(ADR_CNT)
) u_chk (
    .clk          (clk),
    .rst_n        (rst_n),
    .cpu_addr     (cpu_addr),
    .cpu_wr       (cpu_wr),
    .cpu_rdata    (cpu_rdata),
    .sie_ep_sel   (sie_ep_sel),
    .sie_in_tok   (sie_in_tok),
    .sie_in_ack   (sie_in_ack),
    .sie_in_len   (sie_in_len),
    .sie_out_tok  (sie_out_tok),
    .sie_out_done (sie_out_done),
    .sie_out_good (sie_out_good),
    .sie_hs_vld   (sie_hs_vld),
    .sie_hs_kind  (sie_hs_kind),
    .out_dav_irq  (out_dav_irq),
    .st_cnt       (st_cnt),
    .st_armed     (st_armed)
);

// File: tb/sim_ctl_ep_buffer.sv
`timescale 1ns/1ps
module sim_ctl_ep_buffer;

    localparam logic [4:0] A_AUX = 5'h0E, A_DATA = 5'h10, A_CNT = 5'h11, A_FLAG = 5'h12;
    localparam int K_QUIET = 0, K_NAK = 1, K_ACK = 2, K_DATA = 3;

    logic       clk = 1'b0;
    logic       rst_n = 1'b0;
    logic [4:0] cpu_addr = '0;
    logic       cpu_wr = 1'b0, cpu_rd = 1'b0;
    logic [7:0] cpu_wdata = '0;
    logic [7:0] cpu_rdata;
    logic       sie_ep_sel = 1'b0, sie_in_tok = 1'b0, sie_in_rd = 1'b0, sie_in_ack = 1'b0;
    logic [7:0] sie_in_data;
    logic [6:0] sie_in_len;
    logic       sie_out_tok = 1'b0, sie_out_wr = 1'b0, sie_out_done = 1'b0, sie_out_good = 1'b0;
    logic [7:0] sie_out_data = '0;
    logic       sie_hs_vld;
    logic [1:0] sie_hs_kind;
    logic       out_dav_irq;

    int total = 0, bad = 0;
    bit finished = 1'b0;
    int    exp_q[$];
    string tag_q[$];

    always #2 clk = ~clk;   // 250 MHz

    ctl_ep_buffer u0 (.*);

    task automatic chk(input string tag, input int act, input int exp);
        total++;
        if (act != exp) begin
            bad++;
            $display("FAIL %s act=%0d exp=%0d", tag, act, exp);
        end
    endtask

    // monitor: pops the expected handshake for every decision the block emits
    always @(negedge clk) begin
        if (rst_n && sie_hs_vld) begin
            if (exp_q.size() == 0) chk("R3 unexpected handshake", int'(sie_hs_kind), -1);
            else chk(tag_q.pop_front(), int'(sie_hs_kind), exp_q.pop_front());
        end
    end

    task automatic expect_hs(input int k, input string tag);
        exp_q.push_back(k);
        tag_q.push_back(tag);
    endtask

    task automatic cpu_write(input logic [4:0] a, input logic [7:0] d);
        @(negedge clk);
        cpu_addr = a; cpu_wdata = d; cpu_wr = 1'b1;
        @(negedge clk);
        cpu_wr = 1'b0;
    endtask

    task automatic cpu_read(input logic [4:0] a, input bit adv, output logic [7:0] d);
        @(negedge clk);
        cpu_addr = a;
        #1 d = cpu_rdata;
        cpu_rd = adv;
        @(negedge clk);
        cpu_rd = 1'b0;
    endtask

    task automatic in_token(input bit ep, input int k, input string tag);
        expect_hs(k, tag);
        @(negedge clk);
        sie_ep_sel = ep; sie_in_tok = 1'b1;
        @(negedge clk);
        sie_in_tok = 1'b0;
    endtask

    task automatic in_byte(output logic [7:0] d);
        @(negedge clk);
        #1 d = sie_in_data;
        sie_in_rd = 1'b1;
        @(negedge clk);
        sie_in_rd = 1'b0;
    endtask

    task automatic in_acked(input bit ep);
        @(negedge clk);
        sie_ep_sel = ep; sie_in_ack = 1'b1;
        @(negedge clk);
        sie_in_ack = 1'b0; sie_ep_sel = 1'b0;
    endtask

    task automatic out_token();
        @(negedge clk);
        sie_out_tok = 1'b1;
        @(negedge clk);
        sie_out_tok = 1'b0;
    endtask

    task automatic out_byte(input logic [7:0] d);
        @(negedge clk);
        sie_out_wr = 1'b1; sie_out_data = d;
        @(negedge clk);
        sie_out_wr = 1'b0;
    endtask

    task automatic out_end(input bit good);
        @(negedge clk);
        sie_out_done = 1'b1; sie_out_good = good;
        @(negedge clk);
        sie_out_done = 1'b0; sie_out_good = 1'b0;
    endtask

    task automatic do_reset();
        @(negedge clk); rst_n = 1'b0;
        @(negedge clk);
        @(negedge clk); rst_n = 1'b1;
    endtask

    function automatic logic [7:0] pat(input int i);
        return 8'(i * 3 + 1);
    endfunction

    initial begin
        #400000;
        if (!finished) begin
            total++; bad++;
            $display("FAIL watchdog act=timeout exp=done");
            $display("test done: total=%0d bad=%0d", total, bad);
            $finish;
        end
    end

    initial begin
        logic [7:0] d;
        repeat (3) @(negedge clk);
        rst_n = 1'b1;

        // R11 reset state
        cpu_read(A_CNT, 0, d);  chk("R11 count reset", d, 0);
        cpu_read(A_AUX, 0, d);  chk("R11 aux count reset", d, 0);
        cpu_read(A_FLAG, 0, d); chk("R11 flags reset", d, 0);

        // R3 unarmed IN
        in_token(0, K_NAK, "R3 unarmed nak");

        // R1 fill, R2 arm
        for (int i = 0; i < 5; i++) cpu_write(A_DATA, 8'hA0 + 8'(i));
        cpu_write(A_CNT, 8'd5);
        cpu_read(A_CNT, 0, d);  chk("R2 count value", d, 5);
        cpu_read(A_FLAG, 0, d); chk("R2 armed bit", d, 2);

        // R3 armed IN, R4 streaming
        in_token(0, K_DATA, "R3 armed data");
        chk("R3 in_len", sie_in_len, 5);
        for (int i = 0; i < 5; i++) begin
            in_byte(d); chk("R4 in byte", d, 8'hA0 + i);
        end

        // R5 ack disarms
        in_acked(0);
        cpu_read(A_FLAG, 0, d); chk("R5 disarmed", d, 0);
        in_token(0, K_NAK, "R5 nak after ack");

        // R2 clamp and reserved bit
        cpu_write(A_CNT, 8'd100);
        cpu_read(A_CNT, 0, d); chk("R2 clamp 100", d, 64);
        cpu_write(A_CNT, 8'hFF);
        cpu_read(A_CNT, 0, d); chk("R2 clamp ff bit7", d, 64);

        // R1 full fill, wrap, rewind by count write
        for (int i = 0; i < 64; i++) cpu_write(A_DATA, pat(i));
        cpu_write(A_DATA, 8'hAA);
        cpu_write(A_CNT, 8'd0);
        for (int i = 0; i < 64; i++) begin
            cpu_read(A_DATA, 1, d);
            chk("R1 readback", d, (i == 0) ? 8'hAA : pat(i));
        end

        // R6 good OUT (CPU pointer is back at 0 after 64 reads)
        out_token();
        for (int i = 0; i < 10; i++) out_byte(8'h50 + 8'(i));
        expect_hs(K_ACK, "R6 ack");
        out_end(1);
        cpu_read(A_CNT, 0, d);  chk("R6 count", d, 10);
        chk("R6 irq", out_dav_irq, 1);
        for (int i = 0; i < 10; i++) begin
            cpu_read(A_DATA, 1, d); chk("R6 out byte", d, 8'h50 + i);
        end

        // R9 writing zero changes nothing (pointer still at 10)
        cpu_write(A_FLAG, 8'h00);
        cpu_read(A_FLAG, 0, d); chk("R9 flag kept", d & 1, 1);
        cpu_read(A_DATA, 1, d); chk("R9 pointer kept", d, pat(10));

        // R8 pending data: NAK, no change
        expect_hs(K_NAK, "R8 pending nak");
        out_token();
        for (int i = 0; i < 3; i++) out_byte(8'hE0 + 8'(i));
        out_end(1);
        cpu_read(A_CNT, 0, d); chk("R8 count kept", d, 10);
        cpu_write(A_FLAG, 8'h01);
        cpu_read(A_FLAG, 0, d); chk("R9 flag cleared", d & 1, 0);
        for (int i = 0; i < 3; i++) begin
            cpu_read(A_DATA, 1, d); chk("R8 buffer kept", d, 8'h50 + i);
        end

        // R7 bad OUT
        out_token();
        for (int i = 0; i < 4; i++) out_byte(8'h11 + 8'(i));
        expect_hs(K_QUIET, "R7 bad quiet");
        out_end(0);
        cpu_read(A_CNT, 0, d);  chk("R7 count kept", d, 10);
        cpu_read(A_FLAG, 0, d); chk("R7 flag kept", d & 1, 0);

        // R12 overlong OUT
        out_token();
        for (int i = 0; i < 65; i++) out_byte(8'(i));
        expect_hs(K_QUIET, "R12 overlong quiet");
        out_end(1);
        cpu_read(A_CNT, 0, d);  chk("R12 count kept", d, 10);
        cpu_read(A_FLAG, 0, d); chk("R12 flag kept", d & 1, 0);

        // R10 companion endpoint (control stays armed from the count write of 0)
        in_token(1, K_NAK, "R10 aux unarmed");
        cpu_write(A_AUX, 8'd33);
        cpu_read(A_AUX, 0, d);  chk("R10 aux count", d, 33);
        cpu_read(A_FLAG, 0, d); chk("R10 both armed", d, 6);
        in_token(1, K_DATA, "R10 aux data");
        chk("R10 aux len", sie_in_len, 33);
        in_acked(1);
        cpu_read(A_FLAG, 0, d); chk("R10 ctl untouched", d, 2);
        in_token(1, K_NAK, "R10 aux nak after ack");
        cpu_write(A_AUX, 8'd90);
        cpu_read(A_AUX, 0, d);  chk("R10 aux clamp", d, 64);

        // R11 retention across reset
        cpu_write(A_FLAG, 8'h01);
        for (int i = 0; i < 8; i++) cpu_write(A_DATA, 8'hC0 + 8'(i));
        do_reset();
        cpu_read(A_CNT, 0, d);  chk("R11 count cleared", d, 0);
        cpu_read(A_AUX, 0, d);  chk("R11 aux cleared", d, 0);
        cpu_read(A_FLAG, 0, d); chk("R11 flags cleared", d, 0);
        for (int i = 0; i < 8; i++) begin
            cpu_read(A_DATA, 1, d); chk("R11 buffer kept", d, 8'hC0 + i);
        end

        repeat (3) @(negedge clk);
        chk("R3 all handshakes seen", exp_q.size(), 0);
        finished = 1'b1;
        $display("test done: total=%0d bad=%0d", total, bad);
        $finish;
    end

endmodule